// File: doc/BRIEF.md
# Two-Bank Capacitor Phase Sequencer

This block produces every switch-control and timing signal for a front-end stage in which the sample-and-hold and the first residue amplifier share one op-amp and two alternating capacitor banks. It runs from a single fast master clock and an asynchronous active-low reset. A tick counter divides each conversion period into `TICKS` master-clock ticks. Every edge of every output is placed on a tick boundary by decoding that counter, and every output comes straight from a flop, so none of them can glitch.

Each conversion period has an amplify half followed by a hold half. Two main phases mark these halves and are never high together. A guard gap of `GAP` ticks opens each half with both main phases low. Each main phase has an early-falling copy that drives the sampling switches, a bias-steering signal that overlaps its partner around each gap, and an extra-current enable for the op-amp that is active in the hold half.

A comparator latch strobe fires on the last tick of the hold phase. The comparator samples its reference during the amplify phase. Each bank receives a one-hot mode (reset, hold or amplify), and the banks swap roles every period over a four-step schedule. A period toggle is exported so that downstream logic can tag each output word with the bank that produced it.

Top module: `cap_bank_sequencer`

## Requirements
- R1: While `rst_n` is low, all phase, strobe, enable and `bank_sel` outputs are 0 and both bank modes equal reset (3'b001). After `rst_n` rises, the reset state holds through the second rising edge. The third rising edge loads tick 0 of a period with `bank_sel` = 0.
- R2: With tick t counted from 0 to TICKS-1 and H = TICKS/2, `ph_amp` is high for t in [GAP, H-1] and `ph_hold` is high for t in [H+GAP, TICKS-1]. The two are never high together.
- R3: `smp_amp` is high for t in [GAP, H-1-EARLY] and `smp_hold` is high for t in [H+GAP, TICKS-1-EARLY]. Each therefore rises with its main phase and falls EARLY ticks before that phase falls.
- R4: `bias_amp` is high for t in [0, H] and `bias_hold` is high for t in [H, TICKS-1] and at t = 0. At least one of them is always high, and each changes only while both main phases are low.
- R5: `cmp_strobe` is high only at t = TICKS-1, the last tick of `ph_hold`, so it is always followed by the fall of `ph_hold`.
- R6: `trim_en` is high for t in [H, TICKS-1], which is the whole hold half, and low in the amplify half.
- R7: `bank_sel` is 0 in the first period after reset and toggles at every tick 0.
- R8: Mode encoding is bit 0 = reset, bit 1 = hold, bit 2 = amplify. When `bank_sel` = 0, bank X amplifies and bank Y resets in the amplify half, then X resets and Y holds in the hold half. When `bank_sel` = 1, Y amplifies and X resets, then Y resets and X holds.
- R9: Each bank mode is one-hot. Whenever one bank holds or amplifies, the other is in reset. Modes and `bank_sel` change only while both main phases are low.
- R10: Pulling `rst_n` low mid-run forces the R1 state at once, without waiting for a clock edge. The next release restarts the schedule at tick 0 of a `bank_sel` = 0 period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, TICKS ticks per conversion period |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_amp | output | 1 | Main phase of the amplify half |
| ph_hold | output | 1 | Main phase of the hold half |
| smp_amp | output | 1 | Early-falling sampling copy of `ph_amp` |
| smp_hold | output | 1 | Early-falling sampling copy of `ph_hold` |
| bias_amp | output | 1 | Bias-steering enable for the amplify half |
| bias_hold | output | 1 | Bias-steering enable for the hold half |
| cmp_strobe | output | 1 | Comparator latch strobe, one tick |
| trim_en | output | 1 | Extra current-path enable for the shared op-amp |
| bank_sel | output | 1 | Period toggle that tags the active bank |
| bank_x_mode | output | 3 | One-hot mode of bank X |
| bank_y_mode | output | 3 | One-hot mode of bank Y |

## Verification
The block has no data inputs, so the patterns that matter are reset timings. A long directed first run covers more than two full periods, which separates the four bank steps and both `bank_sel` values. Repeated runs of random length are each cut by a reset asserted between clock edges. This exposes wrong restart points, a wrongly kept period toggle, and resets that wait for a clock. One-cycle and multi-cycle reset pulses check that the release delay is the same whatever the pulse length.

// File: rtl/cap_bank_seq_pkg.sv
package cap_bank_seq_pkg;

  typedef enum logic [2:0] {
    BANK_RESET = 3'b001,
    BANK_HOLD  = 3'b010,
    BANK_AMP   = 3'b100
  } bank_mode_e;

  typedef struct packed {
    logic amp;
    logic hold;
    logic smp_amp;
    logic smp_hold;
    logic bias_amp;
    logic bias_hold;
    logic strobe;
    logic trim;
  } phase_bits_t;

endpackage

// File: rtl/cbs_reset_sync.sv
module cbs_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/cbs_tick_counter.sv
module cbs_tick_counter #(
  parameter int TICKS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output logic [$clog2(TICKS)-1:0]   tick,
  output logic                       period_sel
);

  localparam int CW = $clog2(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] tick_q, tick_d;
  logic          sel_q, sel_d;
  logic          wrap;

  always_comb begin
    wrap   = (tick_q == LAST);
    tick_d = wrap ? '0 : tick_q + 1'b1;
    sel_d  = wrap ? ~sel_q : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      tick_q <= tick_d;
      sel_q  <= sel_d;
    end
  end

  assign tick       = tick_q;
  assign period_sel = sel_q;

endmodule

// File: rtl/cbs_phase_decode.sv
module cbs_phase_decode
  import cap_bank_seq_pkg::*;
#(
  parameter int TICKS = 16,
  parameter int GAP   = 2,
  parameter int EARLY = 1
) (
  input  logic [$clog2(TICKS)-1:0] tick,
  output phase_bits_t              phases
);

  localparam int CW   = $clog2(TICKS);
  localparam int HALF = TICKS / 2;
  localparam logic [CW-1:0] A_RISE  = CW'(GAP);
  localparam logic [CW-1:0] A_FALL  = CW'(HALF);
  localparam logic [CW-1:0] A_SFALL = CW'(HALF - EARLY);
  localparam logic [CW-1:0] H_RISE  = CW'(HALF + GAP);
  localparam logic [CW-1:0] H_SFALL = CW'(TICKS - EARLY);
  localparam logic [CW-1:0] MID     = CW'(HALF);
  localparam logic [CW-1:0] LAST    = CW'(TICKS - 1);

  always_comb begin
    phases.amp       = (tick >= A_RISE) && (tick < A_FALL);
    phases.hold      = (tick >= H_RISE);
    phases.smp_amp   = (tick >= A_RISE) && (tick < A_SFALL);
    phases.smp_hold  = (tick >= H_RISE) && (tick < H_SFALL);
    phases.bias_amp  = (tick <= MID);
    phases.bias_hold = (tick >= MID) || (tick == '0);
    phases.strobe    = (tick == LAST);
    phases.trim      = (tick >= MID);
  end

endmodule

// File: rtl/cbs_bank_schedule.sv
module cbs_bank_schedule
  import cap_bank_seq_pkg::*;
#(
  parameter int TICKS = 16,
  parameter int BANKS = 2
) (
  input  logic [$clog2(TICKS)-1:0] tick,
  input  logic                     period_sel,
  output logic [BANKS-1:0][2:0]    modes
);

  localparam int CW = $clog2(TICKS);
  localparam logic [CW-1:0] MID = CW'(TICKS / 2);

  logic amp_half;
  assign amp_half = (tick < MID);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic owner;
    assign owner = (period_sel == b[0]);
    always_comb begin
      if (amp_half) begin
        modes[b] = owner ? BANK_AMP : BANK_RESET;
      end else begin
        modes[b] = owner ? BANK_RESET : BANK_HOLD;
      end
    end
  end

endmodule

// File: rtl/cap_bank_sequencer.sv
module cap_bank_sequencer
  import cap_bank_seq_pkg::*;
#(
  parameter int TICKS = 16,
  parameter int GAP   = 2,
  parameter int EARLY = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       ph_amp,
  output logic       ph_hold,
  output logic       smp_amp,
  output logic       smp_hold,
  output logic       bias_amp,
  output logic       bias_hold,
  output logic       cmp_strobe,
  output logic       trim_en,
  output logic       bank_sel,
  output logic [2:0] bank_x_mode,
  output logic [2:0] bank_y_mode
);

  localparam int CW = $clog2(TICKS);

  logic              rst_sync_n;
  logic [CW-1:0]     tick;
  logic              period_sel;
  phase_bits_t       phases_d, phases_q;
  logic [1:0][2:0]   modes_d, modes_q;
  logic              sel_q;

  cbs_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cbs_tick_counter #(.TICKS(TICKS)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick       (tick),
    .period_sel (period_sel)
  );

  cbs_phase_decode #(.TICKS(TICKS), .GAP(GAP), .EARLY(EARLY)) u_dec (
    .tick   (tick),
    .phases (phases_d)
  );

  cbs_bank_schedule #(.TICKS(TICKS), .BANKS(2)) u_sched (
    .tick       (tick),
    .period_sel (period_sel),
    .modes      (modes_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phases_q <= '0;
      sel_q    <= 1'b0;
      modes_q  <= {BANK_RESET, BANK_RESET};
    end else begin
      phases_q <= phases_d;
      sel_q    <= period_sel;
      modes_q  <= modes_d;
    end
  end

  assign ph_amp      = phases_q.amp;
  assign ph_hold     = phases_q.hold;
  assign smp_amp     = phases_q.smp_amp;
  assign smp_hold    = phases_q.smp_hold;
  assign bias_amp    = phases_q.bias_amp;
  assign bias_hold   = phases_q.bias_hold;
  assign cmp_strobe  = phases_q.strobe;
  assign trim_en     = phases_q.trim;
  assign bank_sel    = sel_q;
  assign bank_x_mode = modes_q[0];
  assign bank_y_mode = modes_q[1];

endmodule

// File: rtl/cap_bank_sequencer_chk.sv
module cap_bank_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ph_amp,
  input logic       ph_hold,
  input logic       smp_amp,
  input logic       smp_hold,
  input logic       bias_amp,
  input logic       bias_hold,
  input logic       cmp_strobe,
  input logic       trim_en,
  input logic       bank_sel,
  input logic [2:0] bank_x_mode,
  input logic [2:0] bank_y_mode
);

  // R2
  main_nonoverlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph_amp && ph_hold));

  // R3
  smp_amp_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_amp |-> ph_amp);

  // R3
  smp_hold_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_hold |-> ph_hold);

  // R3
  amp_early_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_amp) |-> !$past(smp_amp));

  // R3
  hold_early_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph_hold) |-> !$past(smp_hold));

  // R4
  bias_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(bias_amp || bias_hold) |-> (bias_amp || bias_hold));

  // R4
  bias_amp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bias_amp) || $fell(bias_amp)) |-> (!ph_amp && !ph_hold));

  // R4
  bias_hold_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bias_hold) || $fell(bias_hold)) |-> (!ph_amp && !ph_hold));

  // R5
  strobe_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |-> ph_hold);

  // R5
  strobe_before_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |=> !ph_hold);

  // R6
  trim_off_amp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trim_en |-> !ph_amp);

  // R9
  x_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_x_mode) == 1);

  // R9
  y_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_y_mode) == 1);

  // R9
  bank_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_x_mode != 3'b001) |-> (bank_y_mode == 3'b001));

  // R9
  mode_change_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_x_mode != $past(bank_x_mode)) || (bank_sel != $past(bank_sel)))
      |-> (!ph_amp && !ph_hold));

endmodule

bind cap_bank_sequencer cap_bank_sequencer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ph_amp      (ph_amp),
  .ph_hold     (ph_hold),
  .smp_amp     (smp_amp),
  .smp_hold    (smp_hold),
  .bias_amp    (bias_amp),
  .bias_hold   (bias_hold),
  .cmp_strobe  (cmp_strobe),
  .trim_en     (trim_en),
  .bank_sel    (bank_sel),
  .bank_x_mode (bank_x_mode),
  .bank_y_mode (bank_y_mode)
);

// File: tb/cap_bank_sequencer_bench.sv
`timescale 1ns/100ps
module cap_bank_sequencer_bench;

  localparam int N = 16;
  localparam int G = 2;
  localparam int E = 1;
  localparam int H = N / 2;
  localparam int LAT = 3;

  logic clk;
  logic rst_n;
  logic ph_amp, ph_hold, smp_amp, smp_hold, bias_amp, bias_hold;
  logic cmp_strobe, trim_en, bank_sel;
  logic [2:0] bank_x_mode, bank_y_mode;

  int checks;
  int errors;
  bit done;

  cap_bank_sequencer #(.TICKS(N), .GAP(G), .EARLY(E)) u_cap_bank_sequencer (
    .clk         (clk),
    .rst_n       (rst_n),
    .ph_amp      (ph_amp),
    .ph_hold     (ph_hold),
    .smp_amp     (smp_amp),
    .smp_hold    (smp_hold),
    .bias_amp    (bias_amp),
    .bias_hold   (bias_hold),
    .cmp_strobe  (cmp_strobe),
    .trim_en     (trim_en),
    .bank_sel    (bank_sel),
    .bank_x_mode (bank_x_mode),
    .bank_y_mode (bank_y_mode)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Packed view: amp hold samp shold bamp bhold strobe trim sel x[2:0] y[2:0]
  function automatic logic [14:0] expect_at(input int s);
    logic [14:0] v;
    int t, sel;
    logic [2:0] x, y;
    if (s < 0) begin
      v = {9'b0, 3'b001, 3'b001};
    end else begin
      t   = s % N;
      sel = (s / N) % 2;
      if (t < H) begin
        x = (sel == 0) ? 3'b100 : 3'b001;
        y = (sel == 1) ? 3'b100 : 3'b001;
      end else begin
        x = (sel == 1) ? 3'b010 : 3'b001;
        y = (sel == 0) ? 3'b010 : 3'b001;
      end
      v = {(t >= G && t < H), (t >= H + G),
           (t >= G && t < H - E), (t >= H + G && t < N - E),
           (t <= H), (t >= H || t == 0),
           (t == N - 1), (t >= H), logic'(sel[0]), x, y};
    end
    return v;
  endfunction

  function automatic logic [14:0] actual();
    return {ph_amp, ph_hold, smp_amp, smp_hold, bias_amp, bias_hold,
            cmp_strobe, trim_en, bank_sel, bank_x_mode, bank_y_mode};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic check_all(input int s, input string rtag);
    logic [14:0] a, e;
    a = actual();
    e = expect_at(s);
    if (s < 0) begin
      check(a == e, rtag, int'(a), int'(e));
    end else begin
      check(a[14:13] == e[14:13], "R2 main phases", int'(a[14:13]), int'(e[14:13]));
      check(a[12:11] == e[12:11], "R3 sampling phases", int'(a[12:11]), int'(e[12:11]));
      check(a[10:9] == e[10:9], "R4 bias steering", int'(a[10:9]), int'(e[10:9]));
      check(a[8] == e[8], "R5 latch strobe", int'(a[8]), int'(e[8]));
      check(a[7] == e[7], "R6 trim enable", int'(a[7]), int'(e[7]));
      check(a[6] == e[6], "R7 bank_sel", int'(a[6]), int'(e[6]));
      check(a[5:0] == e[5:0], "R8 bank modes", int'(a[5:0]), int'(e[5:0]));
    end
    check(($countones(a[5:3]) == 1) && ($countones(a[2:0]) == 1) &&
          ((a[5:3] == 3'b001) || (a[2:0] == 3'b001)),
          "R9 one-hot and exclusive", int'(a[5:0]), int'(e[5:0]));
  endtask

  task automatic run_cycles(input int n);
    for (int j = 1; j <= n; j++) begin
      @(posedge clk);
      @(negedge clk);
      check_all(j - LAT, "R1 reset state held through sync");
    end
  endtask

  task automatic mid_reset(input int hold_cycles);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    check(actual() == expect_at(-1), "R10 async reset", int'(actual()), int'(expect_at(-1)));
    for (int k = 0; k < hold_cycles; k++) begin
      @(negedge clk);
      check_all(-1, "R1 reset state");
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    void'($urandom(32'd20240611));
    rst_n = 1'b1;
    #1;
    rst_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_all(-1, "R1 reset state");
    end
    rst_n = 1'b1;
    // directed: more than two full periods, all four steps twice
    run_cycles(LAT + 4 * N + 5);
    // directed: one-cycle reset pulse, then restart must be step 1 (R10)
    mid_reset(1);
    run_cycles(LAT + N + 3);
    // random run lengths and reset lengths
    for (int seg = 0; seg < 8; seg++) begin
      int len;
      int hold;
      len  = 10 + int'($urandom % 90);
      hold = 1 + int'($urandom % 4);
      mid_reset(hold);
      run_cycles(LAT + len);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule